// File: doc/BRIEF.md
# I2C Master Bit Engine

This block is the line-level half of an I2C master. A controller above it issues one byte-level command at a time: a start (or repeated start) condition, a byte write, a byte read, or a stop condition. The engine then drives SCL and SDA as open-drain lines. Each line has an output enable that pulls it low and a sampled input. The engine never drives a line high. When the command is over, it reports a one-cycle done or fail pulse, together with the received byte and the acknowledge that the slave returned.

All bus timing is derived from one programmable quarter-bit interval, counted in clock cycles. Each time the engine releases SCL, it waits for the line to actually go high and re-examines it once every quarter. This lets a slave stretch the clock, and a bounded poll count turns a stuck clock into a failure. Start and stop both verify the SDA level and retry a bounded number of times. Any failure releases both lines. Line inputs pass through a two-flop synchronizer before the sequencer looks at them.

Top module: `i2c_bit_master`

## Requirements
- R1: During and after a synchronous reset, scl_oe, sda_oe, busy, done and fail are all low.
- R2: A command is taken only when cmd_valid is high while busy is low. The cmd_op encoding is 0 = start, 1 = write, 2 = read, 3 = stop. busy rises on the following cycle. cmd_valid is ignored while busy is high. Every command ends with exactly one one-cycle pulse of either done or fail, with busy low in that cycle.
- R3: With both lines idle high, a start produces an SDA fall while SCL is high and completes 5 quarters after acceptance.
- R4: A write shifts cmd_data out MSB first, one bit per SCL pulse. ack_rcvd is 1 when SDA is low during the ninth SCL high phase, and 0 otherwise.
- R5: A read shifts eight SDA samples, MSB first, into rdata. On the ninth clock the engine pulls SDA low if cmd_nack is 0 and leaves it released if cmd_nack is 1.
- R6: A stop on a healthy bus produces an SDA rise while SCL is high and completes 4 quarters after acceptance.
- R7: Without clock stretching, a write completes 31 quarters after acceptance and a read completes 29 quarters after acceptance.
- R8: After releasing SCL, the engine samples it once per quarter and proceeds only once it reads high. A slave that holds SCL low for a while delays completion but does not corrupt the byte.
- R9: If SCL still reads low on the (stretch_polls+1)-th poll, the command fails. For a write whose first bit is stretched, this happens stretch_polls+3 quarters after acceptance.
- R10: If SDA reads low after a start releases it, the start is retried. After START_TRIES attempts of 2 quarters each, the command fails.
- R11: If SDA reads low one quarter after a stop releases it, the stop is repeated from SCL low. After STOP_TRIES attempts of 4 quarters each, the command fails.
- R12: In the cycle fail is high, both scl_oe and sda_oe are low.
- R13: During a write or a read, SDA never changes while SCL is high, so no start or stop condition appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request, taken when busy is low |
| cmd_op | input | 2 | Command: 0 start, 1 write, 2 read, 3 stop |
| cmd_data | input | 8 | Byte to write |
| cmd_nack | input | 1 | Read only: 1 releases SDA (no acknowledge) on the ninth clock |
| quarter_cycles | input | QW | Quarter-bit interval in clock cycles, at least 4 |
| stretch_polls | input | PW | Low SCL polls tolerated before a stretch timeout |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse: command succeeded |
| fail | output | 1 | One-cycle pulse: command failed |
| rdata | output | 8 | Last byte read |
| ack_rcvd | output | 1 | Acknowledge seen after the last write |

## Verification
The hardest conditions to reach from the ports are the bounded failure paths: a slave that never lets SCL rise, and an SDA line held low through repeated start or stop attempts. The bench models the bus as a wired-AND of the engine's enables and slave-side pull-downs. It forces these conditions by holding its own pull-downs, and it compares the exact failure cycle against the quarter arithmetic in the requirements. A bounded stretch is produced by holding SCL for a fixed number of cycles after the engine releases it. A stray command is injected in the middle of a read to show that the command is ignored.

// File: rtl/i2c_bit_pkg.sv
package i2c_bit_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } op_e;

  typedef enum logic [4:0] {
    S_IDLE,
    S_ST_REL, S_ST_CHK, S_ST_WAIT, S_ST_HOLD, S_ST_LOW,
    S_WR_SETUP, S_WR_RISE, S_WR_WAIT,
    S_AK_REL, S_AK_RISE, S_AK_WAIT, S_AK_HIGH, S_AK_LOW,
    S_RD_WAIT, S_RD_LOW,
    S_MA_SET, S_MA_RISE, S_MA_WAIT, S_MA_REL, S_MA_END,
    S_SP_SCL, S_SP_SDA, S_SP_WAIT, S_SP_CHK
  } st_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '1;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/i2c_qtimer.sv
module i2c_qtimer #(
  parameter int QW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [QW-1:0] quarter,
  output logic          expired
);
  localparam logic [QW-1:0] ONE = {{(QW-1){1'b0}}, 1'b1};
  logic [QW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (load) begin
      cnt <= quarter - ONE;
      run <= 1'b1;
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - ONE;
    end
  end

  assign expired = run && (cnt == '0);
endmodule

// File: rtl/i2c_bit_fsm.sv
module i2c_bit_fsm
  import i2c_bit_pkg::*;
#(
  parameter int PW          = 16,
  parameter int START_TRIES = 3,
  parameter int STOP_TRIES  = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [7:0]    cmd_data,
  input  logic          cmd_nack,
  input  logic [PW-1:0] stretch_polls,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          tick,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic [7:0]    rdata,
  output logic          ack_rcvd,
  output logic          scl_oe,
  output logic          sda_oe
);
  localparam int MAXT = (START_TRIES > STOP_TRIES) ? START_TRIES : STOP_TRIES;
  localparam int TW   = $clog2(MAXT) + 1;
  localparam logic [TW-1:0] ST_LAST = TW'(START_TRIES - 1);
  localparam logic [TW-1:0] SP_LAST = TW'(STOP_TRIES - 1);

  st_e           st;
  logic [2:0]    bitn;
  logic [7:0]    sh;
  logic [PW-1:0] polls;
  logic [TW-1:0] tries;
  logic          half;
  logic          nack_q;
  logic          in_wait;
  logic          abort_c;

  always_comb begin
    in_wait = st inside {S_ST_WAIT, S_WR_WAIT, S_AK_WAIT, S_RD_WAIT, S_MA_WAIT, S_SP_WAIT};
    abort_c = tick && ((in_wait && !scl_s && polls == stretch_polls) ||
                       (st == S_ST_CHK && !sda_s && tries == ST_LAST) ||
                       (st == S_SP_CHK && !sda_s && tries == SP_LAST));
  end

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    done <= 1'b0;
    fail <= 1'b0;
    if (rst) begin
      st <= S_IDLE;   scl_oe <= 1'b0; sda_oe <= 1'b0;
      rdata <= '0;    ack_rcvd <= 1'b0;
      bitn <= '0;     sh <= '0;       polls <= '0;
      tries <= '0;    half <= 1'b0;   nack_q <= 1'b0;
    end else if (st == S_IDLE) begin
      if (cmd_valid) begin
        bitn <= 3'd7; polls <= '0; tries <= '0; half <= 1'b0;
        sh <= cmd_data; nack_q <= cmd_nack;
        case (op_e'(cmd_op))
          OP_START: begin scl_oe <= 1'b0; st <= S_ST_REL; end
          OP_WRITE: st <= S_WR_SETUP;
          OP_READ:  begin scl_oe <= 1'b0; sda_oe <= 1'b0; st <= S_RD_WAIT; end
          default:  begin scl_oe <= 1'b1; st <= S_SP_SCL; end
        endcase
      end
    end else if (abort_c) begin
      fail <= 1'b1; scl_oe <= 1'b0; sda_oe <= 1'b0; st <= S_IDLE;
    end else if (tick) begin
      if (in_wait && !scl_s) begin
        polls <= polls + 1'b1;            // slave still stretching
      end else begin
        polls <= '0;
        case (st)
          S_ST_REL:   begin sda_oe <= 1'b0; st <= S_ST_CHK; end
          S_ST_CHK:   if (!sda_s) begin tries <= tries + 1'b1; st <= S_ST_REL; end
                      else st <= S_ST_WAIT;
          S_ST_WAIT:  begin sda_oe <= 1'b1; st <= S_ST_HOLD; end
          S_ST_HOLD:  begin scl_oe <= 1'b1; st <= S_ST_LOW; end
          S_WR_SETUP: begin sda_oe <= ~sh[7]; st <= S_WR_RISE; end
          S_WR_RISE:  begin scl_oe <= 1'b0; st <= S_WR_WAIT; end
          S_WR_WAIT: begin
            scl_oe <= 1'b1;
            sh     <= {sh[6:0], 1'b0};
            if (bitn == 3'd0) st <= S_AK_REL;
            else begin bitn <= bitn - 3'd1; st <= S_WR_SETUP; end
          end
          S_AK_REL:   begin sda_oe <= 1'b0; st <= S_AK_RISE; end
          S_AK_RISE:  begin scl_oe <= 1'b0; st <= S_AK_WAIT; end
          S_AK_WAIT:  begin ack_rcvd <= ~sda_s; st <= S_AK_HIGH; end
          S_AK_HIGH:  if (!half) half <= 1'b1;
                      else begin half <= 1'b0; scl_oe <= 1'b1; st <= S_AK_LOW; end
          S_RD_WAIT:  begin sh <= {sh[6:0], sda_s}; scl_oe <= 1'b1; st <= S_RD_LOW; end
          S_RD_LOW: begin
            if (!half) half <= 1'b1;
            else begin
              half <= 1'b0;
              if (bitn == 3'd0) begin rdata <= sh; st <= S_MA_SET; end
              else begin bitn <= bitn - 3'd1; scl_oe <= 1'b0; st <= S_RD_WAIT; end
            end
          end
          S_MA_SET:   begin sda_oe <= ~nack_q; st <= S_MA_RISE; end
          S_MA_RISE:  begin scl_oe <= 1'b0; st <= S_MA_WAIT; end
          S_MA_WAIT:  begin scl_oe <= 1'b1; st <= S_MA_REL; end
          S_MA_REL:   begin sda_oe <= 1'b0; st <= S_MA_END; end
          S_SP_SCL:   begin sda_oe <= 1'b1; st <= S_SP_SDA; end
          S_SP_SDA:   begin scl_oe <= 1'b0; st <= S_SP_WAIT; end
          S_SP_WAIT:  begin sda_oe <= 1'b0; st <= S_SP_CHK; end
          S_SP_CHK:   if (sda_s) begin done <= 1'b1; st <= S_IDLE; end
                      else begin tries <= tries + 1'b1; scl_oe <= 1'b1; st <= S_SP_SCL; end
          S_AK_LOW:   if (!half) half <= 1'b1;
                      else begin half <= 1'b0; done <= 1'b1; st <= S_IDLE; end
          S_ST_LOW, S_MA_END: begin done <= 1'b1; st <= S_IDLE; end
          default:    st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_bit_master.sv
module i2c_bit_master #(
  parameter int QW          = 16,
  parameter int PW          = 16,
  parameter int START_TRIES = 3,
  parameter int STOP_TRIES  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [7:0]    cmd_data,
  input  logic          cmd_nack,
  input  logic [QW-1:0] quarter_cycles,
  input  logic [PW-1:0] stretch_polls,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic [7:0]    rdata,
  output logic          ack_rcvd
);
  logic scl_s, sda_s, tick, tmr_load;

  i2c_line_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({scl_in, sda_in}), .q({scl_s, sda_s})
  );

  assign tmr_load = busy ? tick : cmd_valid;

  i2c_qtimer #(.QW(QW)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .quarter(quarter_cycles), .expired(tick)
  );

  i2c_bit_fsm #(.PW(PW), .START_TRIES(START_TRIES), .STOP_TRIES(STOP_TRIES)) u_fsm (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .cmd_nack(cmd_nack), .stretch_polls(stretch_polls), .scl_s(scl_s), .sda_s(sda_s),
    .tick(tick), .busy(busy), .done(done), .fail(fail), .rdata(rdata),
    .ack_rcvd(ack_rcvd), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );
endmodule

// File: rtl/i2c_bit_master_chk.sv
module i2c_bit_master_chk (
  input logic clk,
  input logic rst,
  input logic cmd_valid,
  input logic busy,
  input logic done,
  input logic fail,
  input logic scl_oe,
  input logic sda_oe
);
  p_fail_release_r12: assert property (@(posedge clk) disable iff (rst)
    fail |-> (!scl_oe && !sda_oe));

  p_done_fail_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(done && fail));

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy) |=> busy);

  p_end_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (done || fail) |-> !busy);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && !cmd_valid) |=> !busy);

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!scl_oe && !sda_oe && !done && !fail));
endmodule

bind i2c_bit_master i2c_bit_master_chk u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .busy(busy),
  .done(done), .fail(fail), .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/i2c_bit_master_test.sv
module i2c_bit_master_test;
  localparam int Q  = 4;
  localparam int SP = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [7:0] cmd_data = 8'd0;
  logic cmd_nack = 1'b0;
  logic scl_oe, sda_oe, busy, done, fail, ack_rcvd;
  logic [7:0] rdata;

  // bench-side bus pulls
  logic hold_scl = 1'b0;
  logic sda_force = 1'b0;
  logic sl_sda = 1'b0;
  logic scl_bus, sda_bus;
  assign scl_bus = !(scl_oe === 1'b1 || hold_scl);
  assign sda_bus = !(sda_oe === 1'b1 || sl_sda || sda_force);

  always #5 clk = ~clk;

  i2c_bit_master uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .cmd_nack(cmd_nack), .quarter_cycles(16'(Q)), .stretch_polls(16'(SP)),
    .scl_in(scl_bus), .sda_in(sda_bus), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .busy(busy), .done(done), .fail(fail), .rdata(rdata), .ack_rcvd(ack_rcvd)
  );

  // behavioural slave: mode 1 receives, mode 2 transmits
  int sl_mode = 0, sl_gen = 0, sl_seen = 0, sl_cnt = 0;
  logic [7:0] sl_tx = 8'h00, sl_rx = 8'h00;
  logic sl_ack = 1'b1, sl_mack = 1'b1, scl_p = 1'b1;

  always @(posedge clk) begin
    scl_p <= scl_bus;
    if (sl_gen != sl_seen) begin
      sl_seen <= sl_gen;
      sl_cnt  <= 0;
    end else if (!scl_p && scl_bus) begin
      if (sl_mode == 1 && sl_cnt < 8) sl_rx <= {sl_rx[6:0], sda_bus};
      if (sl_mode == 2 && sl_cnt == 8) sl_mack <= sda_bus;
      if (sl_cnt < 9) sl_cnt <= sl_cnt + 1;
    end
    if (!scl_bus)
      sl_sda <= (sl_mode == 2 && sl_cnt < 8) ? !sl_tx[7-sl_cnt]
                                              : (sl_mode == 1 && sl_cnt == 8 && sl_ack);
  end

  // per-clock bus monitor and protocol comparison
  logic m_scl = 1'b1, m_sda = 1'b1, data_op = 1'b0;
  int start_cnt = 0, stop_cnt = 0, mon_bad = 0;
  always @(posedge clk) begin
    m_scl <= scl_bus;
    m_sda <= sda_bus;
    if (!rst) begin
      if (m_scl && scl_bus && m_sda && !sda_bus) begin
        start_cnt <= start_cnt + 1;
        if (data_op && busy) mon_bad <= mon_bad + 1;
      end
      if (m_scl && scl_bus && !m_sda && sda_bus) begin
        stop_cnt <= stop_cnt + 1;
        if (data_op && busy) mon_bad <= mon_bad + 1;
      end
      if (done && fail) mon_bad <= mon_bad + 1;
    end
  end

  int checks = 0, failures = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_cmd(input int op, input logic [7:0] d, input logic nk,
                         output int n, output bit f);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op[1:0]; cmd_data = d; cmd_nack = nk;
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 1;
    while (!(done || fail) && n < 5000) begin
      @(negedge clk);
      n++;
    end
    f = fail;
  endtask

  task automatic arm_slave(input int mode, input logic [7:0] tx, input logic ack);
    sl_mode = mode; sl_tx = tx; sl_ack = ack; sl_gen = sl_gen + 1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int n, sc0, pc0;
    bit f;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(!scl_oe && !sda_oe && !busy && !done && !fail, "R1 reset",
          {scl_oe, sda_oe, busy, done, fail}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R3: start on an idle bus
    sc0 = start_cnt;
    run_cmd(0, 8'h00, 1'b0, n, f);
    check(!f && n == 5*Q+1, "R3 start duration", n, 5*Q+1);
    check(start_cnt == sc0 + 1, "R3 start condition", start_cnt - sc0, 1);

    // R4 R7 R13: write with ack
    arm_slave(1, 8'h00, 1'b1);
    data_op = 1'b1;
    run_cmd(1, 8'hA6, 1'b0, n, f);
    check(!f && n == 31*Q+1, "R7 write duration", n, 31*Q+1);
    check(sl_rx == 8'hA6, "R4 write bits MSB first", sl_rx, 8'hA6);
    check(ack_rcvd == 1'b1, "R4 ack seen", ack_rcvd, 1);

    // R4: write with nack
    arm_slave(1, 8'h00, 1'b0);
    run_cmd(1, 8'h3C, 1'b0, n, f);
    check(sl_rx == 8'h3C, "R4 second byte", sl_rx, 8'h3C);
    check(ack_rcvd == 1'b0, "R4 nack seen", ack_rcvd, 0);

    // R5 R7 R2: read with master ack and a stray command mid-read
    arm_slave(2, 8'h5B, 1'b0);
    pc0 = stop_cnt;
    fork
      run_cmd(2, 8'h00, 1'b0, n, f);
      begin
        repeat (6) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd3;
        @(negedge clk);
        cmd_valid = 1'b0;
      end
    join
    check(!f && n == 29*Q+1, "R7 read duration", n, 29*Q+1);
    check(rdata == 8'h5B, "R5 read data", rdata, 8'h5B);
    check(sl_mack == 1'b0, "R5 master ack low", sl_mack, 0);
    repeat (10) @(negedge clk);
    check(!busy && scl_oe, "R2 stray command ignored", busy, 0);
    check(stop_cnt == pc0, "R2 no stop from stray command", stop_cnt - pc0, 0);

    // R5: last-byte read, nack
    arm_slave(2, 8'hC1, 1'b0);
    run_cmd(2, 8'h00, 1'b1, n, f);
    check(rdata == 8'hC1, "R5 read data last", rdata, 8'hC1);
    check(sl_mack == 1'b1, "R5 master nack released", sl_mack, 1);
    data_op = 1'b0;

    // R6: stop
    arm_slave(0, 8'h00, 1'b0);
    pc0 = stop_cnt;
    run_cmd(3, 8'h00, 1'b0, n, f);
    check(!f && n == 4*Q+1, "R6 stop duration", n, 4*Q+1);
    repeat (2) @(negedge clk);
    check(stop_cnt == pc0 + 1 && !scl_oe && !sda_oe, "R6 stop condition", stop_cnt - pc0, 1);

    // R8: bounded stretch on the first bit
    run_cmd(0, 8'h00, 1'b0, n, f);
    arm_slave(1, 8'h00, 1'b1);
    data_op = 1'b1;
    hold_scl = 1'b1;
    fork
      run_cmd(1, 8'h96, 1'b0, n, f);
      begin
        @(negedge scl_oe);
        repeat (10) @(negedge clk);
        hold_scl = 1'b0;
      end
    join
    check(!f && n > 31*Q+1, "R8 stretch delays completion", n, 31*Q+2);
    check(sl_rx == 8'h96 && ack_rcvd, "R8 stretched byte intact", sl_rx, 8'h96);

    // R9 R12: stretch timeout
    arm_slave(0, 8'h00, 1'b0);
    hold_scl = 1'b1;
    run_cmd(1, 8'hFF, 1'b0, n, f);
    check(f && n == (SP+3)*Q+1, "R9 stretch timeout", n, (SP+3)*Q+1);
    check(!scl_oe && !sda_oe, "R12 lines released on timeout", {scl_oe, sda_oe}, 0);
    data_op = 1'b0;
    @(negedge clk);
    hold_scl = 1'b0;
    repeat (4) @(negedge clk);

    // R10 R12: start with SDA stuck low
    sda_force = 1'b1;
    repeat (4) @(negedge clk);
    run_cmd(0, 8'h00, 1'b0, n, f);
    check(f && n == 3*2*Q+1, "R10 start retries then fails", n, 3*2*Q+1);
    check(!scl_oe && !sda_oe, "R12 lines released after start", {scl_oe, sda_oe}, 0);

    // R11: stop with SDA stuck low
    run_cmd(3, 8'h00, 1'b0, n, f);
    check(f && n == 3*4*Q+1, "R11 stop retries then fails", n, 3*4*Q+1);
    sda_force = 1'b0;
    repeat (4) @(negedge clk);

    // R13: per-clock monitor results
    check(mon_bad == 0, "R13 no condition inside data", mon_bad, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("watchdog expired: FAIL R2 actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
    $finish;
  end
endmodule